// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external bus master read and write a bank of 8-bit control registers over a two-wire serial link (clock line and data line). A fast system clock oversamples both wires through synchronisers. Edges on the synchronised lines mark bit boundaries and the bus conditions that open and close a transfer. Every transfer begins with a byte holding a 7-bit device identifier and a direction bit. In a write, the next byte loads the register pointer and any further bytes are stored at that pointer. In a read there is no pointer phase: bytes come back starting at whatever pointer value the last transfer left behind.

The pointer is kept between transfers and advances by one after every data byte, in both directions, wrapping at the top of the address space. The data line is pulled low through an open-drain enable and is never driven high. Register-file writes leave through a valid/ready port. The request is raised once the eighth bit of a data byte has been sampled. Address and data then hold steady until `wr_ready` is seen. If the register file has not accepted the byte by the time the acknowledge bit opens, the request is withdrawn, the byte is refused on the bus, and the block goes silent until the next bus condition. Register reads use a plain port: `rd_data` must follow `rd_addr` combinationally.

Top module: `regbus_serial_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_oe` = 0), holds `wr_valid` low and the register pointer (`rd_addr`) is 0.
- R2: The slave acknowledges the first byte of a transfer (pulls the data line low during the ninth clock) only when its upper seven bits, sent MSB first, equal `DEV_ID`. Otherwise it acknowledges nothing, writes nothing and leaves the pointer unchanged until the next start or stop.
- R3: In a transfer whose first-byte LSB is 0 (write), the second byte is acknowledged and loaded into the register pointer.
- R4: Each later byte of a write is offered on the write port at the current pointer; once accepted it is acknowledged and the pointer increments, wrapping from 0xFF to 0x00.
- R5: In a transfer whose first-byte LSB is 1 (read), the slave shifts out the register at the pointer and the pointer increments after every byte sent; on a master acknowledge (data line low in the ninth clock) the next register follows.
- R6: On a master non-acknowledge the slave releases the data line and stays silent until a start or stop; a later read resumes at the advanced pointer.
- R7: A write transfer that ends after the pointer byte changes the pointer and performs no register write.
- R8: While `wr_valid` is high and `wr_ready` low, `wr_addr` and `wr_data` stay stable; if the byte is not accepted before its acknowledge bit, the request is withdrawn, the byte is not acknowledged and no register is written.
- R9: `sda_oe` changes only while the clock line is low.
- R10: A start condition (data falling while clock is high) in any state, including mid-byte, restarts reception of a first byte; a stop (data rising while clock is high) returns the slave to idle.
- R11: Data travels MSB first in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_valid | output | 1 | Register write request |
| wr_ready | input | 1 | Register file accepts the write |
| wr_addr | output | ADDR_W | Write address (current pointer) |
| wr_data | output | 8 | Write data |
| rd_addr | output | ADDR_W | Read address, equal to the register pointer |
| rd_data | input | 8 | Register contents at `rd_addr`, combinational |

## Verification
The checker watches, on every cycle, that the open-drain enable never moves while the clock line is high. It also checks that a stalled write request keeps its address and data, that an accepted write advances the pointer by exactly one, and that a write request never overlaps the slave driving the bus. Identifier matching, pointer persistence across transfers, wrap-around, the pointer-only write, refusal under back-pressure, master non-acknowledge and an aborted byte cut short by a repeated start are only visible through whole bus scenarios. The bench drives those as a master and scores the bytes returned and the writes produced.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RX_ID,
    ST_ACK_ID,
    ST_RX_PTR,
    ST_ACK_PTR,
    ST_RX_DATA,
    ST_ACK_DATA,
    ST_TX_DATA,
    ST_TX_ACK,
    ST_IGNORE
  } rss_state_e;
endpackage

// File: rtl/rss_sync.sv
// Line synchroniser and bus-condition detector for the clock and data wires.
module rss_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_lvl,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;   // index 0: clock wire, index 1: data wire

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] prv;

  assign raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl[g] = chain[STAGES-1];
    assign prv[g] = last;
  end

  assign scl_rise  =  lvl[0] & ~prv[0];
  assign scl_fall  = ~lvl[0] &  prv[0];
  assign sda_lvl   =  lvl[1];
  assign start_det =  prv[1] & ~lvl[1] & lvl[0] & prv[0];
  assign stop_det  = ~prv[1] &  lvl[1] & lvl[0] & prv[0];
endmodule

// File: rtl/rss_ctrl.sv
// Transfer sequencer: byte shifting, acknowledge handling, pointer and write port.
module rss_ctrl
  import rss_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'h2A,
  parameter int         ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  rss_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [ADDR_W-1:0] ptr;
  logic              is_read;
  logic              accepted;
  logic              m_ack;
  logic              wr_fire;
  logic              receiving;

  assign wr_fire   = wr_valid & wr_ready;
  assign receiving = (state == ST_RX_ID) || (state == ST_RX_PTR) || (state == ST_RX_DATA);
  assign wr_addr   = ptr;
  assign rd_addr   = ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      is_read  <= 1'b0;
      accepted <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      if (wr_fire) begin
        wr_valid <= 1'b0;
        accepted <= 1'b1;
        ptr      <= ptr + 1'b1;
      end
      if (start_det) begin
        state    <= ST_RX_ID;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        wr_valid <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        sda_oe   <= 1'b0;
        wr_valid <= 1'b0;
      end else if (receiving) begin
        if (scl_rise) begin
          rx_sh <= {rx_sh[BYTE_W-2:0], sda_lvl};
          cnt   <= cnt + 1'b1;
          if (state == ST_RX_DATA && cnt == CNT_LAST) begin
            wr_valid <= 1'b1;
            wr_data  <= {rx_sh[BYTE_W-2:0], sda_lvl};
            accepted <= 1'b0;
          end
        end else if (scl_fall && cnt == CNT_FULL) begin
          cnt <= '0;
          unique case (state)
            ST_RX_ID: begin
              if (rx_sh[BYTE_W-1:1] == DEV_ID) begin
                is_read <= rx_sh[0];
                sda_oe  <= 1'b1;
                state   <= ST_ACK_ID;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_RX_PTR: begin
              ptr    <= rx_sh[ADDR_W-1:0];
              sda_oe <= 1'b1;
              state  <= ST_ACK_PTR;
            end
            default: begin
              if (accepted || wr_fire) begin
                sda_oe <= 1'b1;
                state  <= ST_ACK_DATA;
              end else begin
                wr_valid <= 1'b0;
                state    <= ST_IGNORE;
              end
            end
          endcase
        end
      end else begin
        unique case (state)
          ST_ACK_ID: if (scl_fall) begin
            cnt <= '0;
            if (is_read) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= ST_TX_DATA;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX_PTR;
            end
          end
          ST_ACK_PTR, ST_ACK_DATA: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            state  <= ST_RX_DATA;
          end
          ST_TX_DATA: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == CNT_FULL) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                state  <= ST_TX_ACK;
              end else if (cnt != '0) begin
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe <= ~tx_sh[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_lvl;
              ptr   <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (m_ack) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
                state  <= ST_TX_DATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data
);
  assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (!wr_valid || ($stable(wr_addr) && $stable(wr_data))));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));

  assert_no_drive_during_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !sda_oe);
endmodule

bind regbus_serial_slave rss_checker #(.ADDR_W(ADDR_W)) u_rss_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .wr_addr (wr_addr),
  .wr_data (wr_data)
);

// File: rtl/regbus_serial_slave.sv
module regbus_serial_slave
  import rss_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'h2A,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  logic scl_rise, scl_fall, sda_lvl, start_det, stop_det;

  rss_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_i),
    .sda_in   (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_lvl),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  rss_ctrl #(.DEV_ID(DEV_ID), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_lvl  (sda_lvl),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/sim_regbus_serial_slave.sv
module sim_regbus_serial_slave;
  localparam logic [6:0] ID = 7'h2A;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe, wr_valid, wr_ready;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic [7:0] regs [256];
  logic [15:0] wq [$];
  int checks = 0;
  int fails = 0;
  int bp_mode = 0;
  int vcnt = 0;
  int r9_viol = 0;
  logic prev_oe = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus  = sda_m & ~sda_oe;
  assign rd_data  = regs[rd_addr];
  assign wr_ready = (bp_mode == 0) || (bp_mode == 2 && vcnt >= 4);

  regbus_serial_slave #(.DEV_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) vcnt <= wr_valid ? vcnt + 1 : 0;

  // Scoreboard monitor: every accepted write is matched against the queue.
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      regs[wr_addr] = wr_data;
      if (wq.size() == 0) chk("R4 unexpected write", {wr_addr, wr_data}, 16'hFFFF);
      else chk("R4 write port", {wr_addr, wr_data}, wq.pop_front());
    end
    if (rst_n && sda_oe != prev_oe && scl) r9_viol++;
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    b = sda_bus; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~ack);
  endtask

  // Driver: a write transfer; expected writes are pushed to the scoreboard.
  task automatic write_xfer(input logic [7:0] p, input logic [7:0] d [], input bit expect_store);
    logic a;
    bus_start();
    send_byte({ID, 1'b0}, a); chk("R2 id ack (write)", a, 1);
    send_byte(p, a);          chk("R3 pointer ack", a, 1);
    foreach (d[i]) begin
      if (expect_store) wq.push_back({8'(p + 8'(i)), d[i]});
      send_byte(d[i], a);     chk("R4 data ack", a, expect_store ? 1 : 0);
    end
    bus_stop();
  endtask

  task automatic read_check(input logic [7:0] exp [], input string req);
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte({ID, 1'b1}, a); chk("R2 id ack (read)", a, 1);
    foreach (exp[i]) begin
      recv_byte(v, i != exp.size() - 1);
      chk(req, v, exp[i]);
    end
    tick(Q);
    chk("R6 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic a;
    logic [7:0] v;
    for (int i = 0; i < 256; i++) regs[i] = 8'(i) ^ 8'hA5;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    chk("R1 sda_oe after reset", sda_oe, 0);
    chk("R1 wr_valid after reset", wr_valid, 0);
    chk("R1 pointer after reset", rd_addr, 0);

    // R5/R11: read straight after reset, MSB first from pointer 0
    read_check('{8'hA5, 8'hA4}, "R5 R11 read data");
    chk("R6 pointer advanced past nacked byte", rd_addr, 8'h02);

    // R3/R4: burst write
    write_xfer(8'h10, '{8'h3C, 8'hC3, 8'h5A}, 1'b1);
    chk("R4 pointer after burst", rd_addr, 8'h13);

    // R7 + R10: pointer-only write, repeated start, read back
    bus_start();
    send_byte({ID, 1'b0}, a); chk("R2 id ack", a, 1);
    send_byte(8'h10, a);      chk("R3 pointer ack", a, 1);
    tick(Q);
    chk("R7 pointer loaded without write", rd_addr, 8'h10);
    chk("R7 no write queued", wq.size(), 0);
    read_check('{8'h3C, 8'hC3, 8'h5A}, "R10 R5 read after repeated start");

    // R6: a new read resumes at the advanced pointer
    read_check('{8'hB6}, "R6 resume read");

    // R2: wrong identifier is ignored
    bus_start();
    send_byte({ID ^ 7'h01, 1'b0}, a); chk("R2 foreign id not acked", a, 0);
    send_byte(8'h20, a);              chk("R2 ignored pointer byte", a, 0);
    send_byte(8'h55, a);              chk("R2 ignored data byte", a, 0);
    bus_stop();
    chk("R2 pointer unchanged", rd_addr, 8'h14);
    read_check('{8'hB1}, "R2 read after foreign transfer");

    // R4: pointer wrap 0xFF -> 0x00
    write_xfer(8'hFF, '{8'h11, 8'h22}, 1'b1);
    chk("R4 wrapped pointer", rd_addr, 8'h01);
    bus_start();
    send_byte({ID, 1'b0}, a);
    send_byte(8'hFF, a);
    read_check('{8'h11, 8'h22}, "R4 read across wrap");

    // R8: back-pressure refusal, then delayed acceptance
    bp_mode = 1;
    write_xfer(8'h40, '{8'h77}, 1'b0);
    chk("R8 refused byte leaves pointer", rd_addr, 8'h40);
    bp_mode = 2;
    write_xfer(8'h40, '{8'h99}, 1'b1);
    bp_mode = 0;
    chk("R8 delayed accept advances pointer", rd_addr, 8'h41);

    // R10: start in the middle of a first byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    read_check('{8'hE4}, "R10 read after aborted byte");

    tick(Q);
    chk("R4 scoreboard drained", wq.size(), 0);
    chk("R9 sda_oe moved while clock high", r9_viol, 0);
    finish_run();
  end
endmodule